// File: doc/BRIEF.md
# Four-Port Bufferless Deflection Router Datapath

This block is the routing datapath of a mesh node that never stores a flit. On every cycle it takes in up to four flits, one from each neighbouring link (north, east, south, west), together with one candidate flit from the local node's injection queue. It sends every flit it does not eject back out on some link in the next cycle. A flit that loses a conflict for its wanted link is deflected onto another free link, so the count of flits in the network stays the same.

First, a local-access stage removes at most one flit addressed to this node, and it puts the queued local flit into an empty slot if one exists. Second, a two-stage network of 2x2 swap elements arranges the surviving flits onto the four output links. Each element decides alone, from its two inputs only, whether to pass straight or to swap. One flag marks flits of the single privileged ("golden") packet. A golden flit wins every element it passes through, so it always makes progress toward its destination, and this gives freedom from livelock without a full age sort.

The datapath has a register on its inputs and a register on its outputs. Results therefore show up two clock edges after the inputs are presented.

Top module: `defl_router`

## Requirements
- R1: A flit is packed MSB to LSB as {valid, golden, dst_x[X_W], dst_y[Y_W], packet id[PKT_W], seq[SEQ_W]}. A flit presented on the inputs appears on the outputs after exactly two rising clock edges, and the cycle between shows nothing from it.
- R2: While rst_ni is low, every output flit, the ejected flit and the injection acknowledge are all zero.
- R3: The wanted link follows X-then-Y order. If dst_x is greater than the node's X, the flit goes east; if dst_x is smaller, it goes west. If dst_x equals the node's X, a dst_y greater than the node's Y goes south and a smaller dst_y goes north. If both coordinates match, the flit is local. Output index 0/1/2/3 is north/east/south/west.
- R4: At most one valid local flit is ejected per cycle. A golden local flit is chosen before a non-golden one. Among golden local flits the lowest seq is chosen. All remaining ties go to the lowest input index.
- R5: A valid injection flit is accepted, and inj_ack_o is raised in the same cycle its effect shows on the outputs, exactly when fewer than four link flits remain after ejection.
- R6: Every valid link flit that is not ejected, and every accepted injection flit, leaves on exactly one output link, bit for bit unchanged. No other valid flit appears.
- R7: Consider the golden output flits of a cycle. If the one with the lowest seq (or the only one) is not local, it leaves on its R3 link.
- R8: When only one valid flit leaves the router in a cycle and it is not local, it leaves on its R3 link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_flit_i | input | 4 x FLIT_W | Incoming link flits, index 0..3 = N,E,S,W |
| inj_flit_i | input | FLIT_W | Head of the local injection queue (valid in MSB) |
| inj_ack_o | output | 1 | The injection flit of two edges earlier was taken |
| out_flit_o | output | 4 x FLIT_W | Outgoing link flits, index 0..3 = N,E,S,W |
| ej_flit_o | output | FLIT_W | Flit ejected to the local node (valid in MSB) |

## Verification
The bench builds the router with 3-bit coordinates at node (3,3). From that position, destinations lie on both sides in X and in Y, so every output link and the local case can be reached. A 2-bit sequence field lets two or three flits of the golden packet carry different sequence numbers in one cycle. This makes the lower-sequence tie-break visible, both in ejection and in contention for a link. With a 6-bit packet id, every flit in a vector can carry its own tag, so the bench can tell whether a flit was lost or duplicated from what it sees at the ports alone.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int NPORT = 4;

  // Encoding is relied upon: bit 1 selects the S/W half, bit 0 the E/W side.
  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;
endpackage

// File: rtl/defl_route_calc.sv
module defl_route_calc
  import defl_pkg::*;
#(
  parameter int X_W  = 3,
  parameter int Y_W  = 3,
  parameter int MY_X = 0,
  parameter int MY_Y = 0
) (
  input  logic [X_W-1:0] dst_x_i,
  input  logic [Y_W-1:0] dst_y_i,
  output dir_e           dir_o,
  output logic           local_o
);
  localparam logic [X_W-1:0] HOME_X = X_W'(MY_X);
  localparam logic [Y_W-1:0] HOME_Y = Y_W'(MY_Y);

  always_comb begin
    local_o = 1'b0;
    if (dst_x_i > HOME_X)      dir_o = DIR_E;
    else if (dst_x_i < HOME_X) dir_o = DIR_W;
    else if (dst_y_i > HOME_Y) dir_o = DIR_S;
    else if (dst_y_i < HOME_Y) dir_o = DIR_N;
    else begin
      dir_o   = DIR_N;
      local_o = 1'b1;
    end
  end
endmodule

// File: rtl/defl_ej_inj.sv
module defl_ej_inj
  import defl_pkg::*;
#(
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter int PKT_W = 6,
  parameter int SEQ_W = 2,
  parameter int MY_X  = 0,
  parameter int MY_Y  = 0,
  localparam int FLIT_W = 2 + X_W + Y_W + PKT_W + SEQ_W
) (
  input  logic [NPORT-1:0][FLIT_W-1:0] slots_i,
  input  logic [FLIT_W-1:0]            inj_flit_i,
  output logic [NPORT-1:0][FLIT_W-1:0] slots_o,
  output logic [FLIT_W-1:0]            ej_flit_o,
  output logic                         inj_ack_o
);
  localparam int VLD_B = FLIT_W - 1;
  localparam int GLD_B = FLIT_W - 2;
  localparam int DY_LO = SEQ_W + PKT_W;
  localparam int DX_LO = DY_LO + Y_W;

  logic [NPORT-1:0] is_local;

  for (genvar p = 0; p < NPORT; p++) begin : g_loc
    assign is_local[p] = slots_i[p][VLD_B]
                       && (slots_i[p][DX_LO +: X_W] == X_W'(MY_X))
                       && (slots_i[p][DY_LO +: Y_W] == Y_W'(MY_Y));
  end

  logic             have;
  logic [1:0]       sel;
  logic             sel_g;
  logic [SEQ_W-1:0] sel_s;

  // Golden first, lowest seq among golden, lowest index otherwise.
  always_comb begin
    have  = 1'b0;
    sel   = '0;
    sel_g = 1'b0;
    sel_s = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (is_local[p]) begin
        if (!have
            || (slots_i[p][GLD_B] && !sel_g)
            || (slots_i[p][GLD_B] && sel_g && (slots_i[p][SEQ_W-1:0] < sel_s))) begin
          have  = 1'b1;
          sel   = 2'(p);
          sel_g = slots_i[p][GLD_B];
          sel_s = slots_i[p][SEQ_W-1:0];
        end
      end
    end
  end

  always_comb begin
    slots_o   = slots_i;
    ej_flit_o = '0;
    if (have) begin
      ej_flit_o    = slots_i[sel];
      slots_o[sel] = '0;
    end
    inj_ack_o = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (!inj_ack_o && inj_flit_i[VLD_B] && !slots_o[p][VLD_B]) begin
        slots_o[p] = inj_flit_i;
        inj_ack_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/defl_swap_elem.sv
module defl_swap_elem
  import defl_pkg::*;
#(
  parameter int X_W     = 3,
  parameter int Y_W     = 3,
  parameter int PKT_W   = 6,
  parameter int SEQ_W   = 2,
  parameter int MY_X    = 0,
  parameter int MY_Y    = 0,
  parameter int DIR_BIT = 1,
  localparam int FLIT_W = 2 + X_W + Y_W + PKT_W + SEQ_W
) (
  input  logic [FLIT_W-1:0] a_i,
  input  logic [FLIT_W-1:0] b_i,
  input  logic              arb_i,
  output logic [FLIT_W-1:0] o0_o,
  output logic [FLIT_W-1:0] o1_o
);
  localparam int VLD_B = FLIT_W - 1;
  localparam int GLD_B = FLIT_W - 2;
  localparam int DY_LO = SEQ_W + PKT_W;
  localparam int DX_LO = DY_LO + Y_W;

  dir_e dir_a, dir_b;
  logic loc_a, loc_b;

  defl_route_calc #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_rt_a (
    .dst_x_i(a_i[DX_LO +: X_W]), .dst_y_i(a_i[DY_LO +: Y_W]),
    .dir_o(dir_a), .local_o(loc_a)
  );
  defl_route_calc #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_rt_b (
    .dst_x_i(b_i[DX_LO +: X_W]), .dst_y_i(b_i[DY_LO +: Y_W]),
    .dir_o(dir_b), .local_o(loc_b)
  );

  logic [1:0] dcode_a, dcode_b;
  logic       want1_a, want1_b, a_wins, swap;

  assign dcode_a = dir_a;
  assign dcode_b = dir_b;
  assign want1_a = dcode_a[DIR_BIT];
  assign want1_b = dcode_b[DIR_BIT];

  always_comb begin
    if (!a_i[VLD_B])                  a_wins = 1'b0;
    else if (!b_i[VLD_B])             a_wins = 1'b1;
    else if (a_i[GLD_B] != b_i[GLD_B]) a_wins = a_i[GLD_B];
    else if (a_i[GLD_B] && (a_i[SEQ_W-1:0] != b_i[SEQ_W-1:0]))
      a_wins = a_i[SEQ_W-1:0] < b_i[SEQ_W-1:0];
    else                              a_wins = arb_i;
  end

  // Winner steers; a local winner has no preference and passes straight.
  always_comb begin
    if (!a_i[VLD_B] && !b_i[VLD_B]) swap = 1'b0;
    else if (a_wins)                swap = want1_a && !loc_a;
    else                            swap = !want1_b && !loc_b;
  end

  assign o0_o = swap ? b_i : a_i;
  assign o1_o = swap ? a_i : b_i;
endmodule

// File: rtl/defl_router.sv
module defl_router
  import defl_pkg::*;
#(
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter int PKT_W = 6,
  parameter int SEQ_W = 2,
  parameter int MY_X  = 3,
  parameter int MY_Y  = 3,
  localparam int FLIT_W = 2 + X_W + Y_W + PKT_W + SEQ_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NPORT-1:0][FLIT_W-1:0] in_flit_i,
  input  logic [FLIT_W-1:0]            inj_flit_i,
  output logic                         inj_ack_o,
  output logic [NPORT-1:0][FLIT_W-1:0] out_flit_o,
  output logic [FLIT_W-1:0]            ej_flit_o
);
  localparam int NSTAGE = 2;
  localparam int NELEM  = NPORT / 2;

  logic [NPORT-1:0][FLIT_W-1:0] in_q, slots, mid, perm;
  logic [FLIT_W-1:0]            inj_q, ej_d;
  logic                         ack_d;
  logic [3:0]                   lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      inj_q <= '0;
    end else begin
      in_q  <= in_flit_i;
      inj_q <= inj_flit_i;
    end
  end

  // Free-running pseudo-random tie-break source, one bit per element.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= 4'b1001;
    else         lfsr_q <= {lfsr_q[2:0], lfsr_q[3] ^ lfsr_q[2]};
  end

  defl_ej_inj #(
    .X_W(X_W), .Y_W(Y_W), .PKT_W(PKT_W), .SEQ_W(SEQ_W), .MY_X(MY_X), .MY_Y(MY_Y)
  ) u_ej_inj (
    .slots_i   (in_q),
    .inj_flit_i(inj_q),
    .slots_o   (slots),
    .ej_flit_o (ej_d),
    .inj_ack_o (ack_d)
  );

  // Stage 0 pairs (N,S) and (E,W); stage 1 covers {N,E} and {S,W} outputs.
  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    for (genvar k = 0; k < NELEM; k++) begin : g_elem
      if (s == 0) begin : g_first
        defl_swap_elem #(
          .X_W(X_W), .Y_W(Y_W), .PKT_W(PKT_W), .SEQ_W(SEQ_W),
          .MY_X(MY_X), .MY_Y(MY_Y), .DIR_BIT(1)
        ) u_el (
          .a_i  (slots[k]),
          .b_i  (slots[k+NELEM]),
          .arb_i(lfsr_q[k]),
          .o0_o (mid[k]),
          .o1_o (mid[k+NELEM])
        );
      end else begin : g_second
        defl_swap_elem #(
          .X_W(X_W), .Y_W(Y_W), .PKT_W(PKT_W), .SEQ_W(SEQ_W),
          .MY_X(MY_X), .MY_Y(MY_Y), .DIR_BIT(0)
        ) u_el (
          .a_i  (mid[2*k]),
          .b_i  (mid[2*k+1]),
          .arb_i(lfsr_q[NELEM+k]),
          .o0_o (perm[2*k]),
          .o1_o (perm[2*k+1])
        );
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_flit_o <= '0;
      ej_flit_o  <= '0;
      inj_ack_o  <= 1'b0;
    end else begin
      out_flit_o <= perm;
      ej_flit_o  <= ej_d;
      inj_ack_o  <= ack_d;
    end
  end
endmodule

// File: rtl/defl_router_chk.sv
module defl_router_chk
  import defl_pkg::*;
#(
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter int PKT_W = 6,
  parameter int SEQ_W = 2,
  parameter int MY_X  = 3,
  parameter int MY_Y  = 3,
  localparam int FLIT_W = 2 + X_W + Y_W + PKT_W + SEQ_W
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NPORT-1:0][FLIT_W-1:0] in_flit_i,
  input logic [FLIT_W-1:0]            inj_flit_i,
  input logic                         inj_ack_o,
  input logic [NPORT-1:0][FLIT_W-1:0] out_flit_o,
  input logic [FLIT_W-1:0]            ej_flit_o
);
  localparam int VLD_B = FLIT_W - 1;
  localparam int GLD_B = FLIT_W - 2;
  localparam int DY_LO = SEQ_W + PKT_W;
  localparam int DX_LO = DY_LO + Y_W;

  // 0..3 = N,E,S,W; 4 = local
  function automatic int xy_port(logic [FLIT_W-1:0] f);
    if (f[DX_LO +: X_W] > X_W'(MY_X)) return 1;
    if (f[DX_LO +: X_W] < X_W'(MY_X)) return 3;
    if (f[DY_LO +: Y_W] > Y_W'(MY_Y)) return 2;
    if (f[DY_LO +: Y_W] < Y_W'(MY_Y)) return 0;
    return 4;
  endfunction

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  logic [2:0] n_in, n_out, n_gold;
  logic       gold_ok, lone_ok, gold_local_out;

  always_comb begin
    n_in = '0; n_out = '0; n_gold = '0;
    gold_ok = 1'b1; lone_ok = 1'b1; gold_local_out = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      n_in  = n_in  + 3'(in_flit_i[p][VLD_B]);
      n_out = n_out + 3'(out_flit_o[p][VLD_B]);
      if (out_flit_o[p][VLD_B] && out_flit_o[p][GLD_B]) begin
        n_gold = n_gold + 3'd1;
        if (xy_port(out_flit_o[p]) == 4) gold_local_out = 1'b1;
        else if (xy_port(out_flit_o[p]) != p) gold_ok = 1'b0;
      end
      if (out_flit_o[p][VLD_B] && xy_port(out_flit_o[p]) != 4 && xy_port(out_flit_o[p]) != p)
        lone_ok = 1'b0;
    end
  end

  a_r6_flit_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q == 2'd2 |->
      (4'(n_out) + 4'(ej_flit_o[VLD_B])) == (4'($past(n_in, 2)) + 4'(inj_ack_o)));

  a_r5_ack_needs_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && inj_ack_o) |-> $past(inj_flit_i[VLD_B], 2));

  a_r5_refuse_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $past(inj_flit_i[VLD_B], 2) && !inj_ack_o) |-> n_out == 3'd4);

  a_r4_ej_is_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ej_flit_o[VLD_B] |-> xy_port(ej_flit_o) == 4);

  a_r4_golden_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ej_flit_o[VLD_B] && !ej_flit_o[GLD_B]) |-> !gold_local_out);

  a_r7_golden_productive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_gold == 3'd1 |-> gold_ok);

  a_r8_lone_productive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_out == 3'd1 |-> lone_ok);
endmodule

bind defl_router defl_router_chk #(
  .X_W(X_W), .Y_W(Y_W), .PKT_W(PKT_W), .SEQ_W(SEQ_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (.*);

// File: tb/tb_defl_router.sv
`timescale 1ns/1ps
module tb_defl_router;
  localparam int X_W   = 3;
  localparam int Y_W   = 3;
  localparam int PKT_W = 6;
  localparam int SEQ_W = 2;
  localparam int MY_X  = 3;
  localparam int MY_Y  = 3;
  localparam int FW    = 2 + X_W + Y_W + PKT_W + SEQ_W;
  localparam int VW    = 2 + 5 * FW;
  localparam int NV    = 12;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [3:0][FW-1:0]    in_flit = '0;
  logic [FW-1:0]         inj_flit = '0;
  logic                  inj_ack;
  logic [3:0][FW-1:0]    out_flit;
  logic [FW-1:0]         ej_flit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  defl_router #(
    .X_W(X_W), .Y_W(Y_W), .PKT_W(PKT_W), .SEQ_W(SEQ_W), .MY_X(MY_X), .MY_Y(MY_Y)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_flit_i(in_flit), .inj_flit_i(inj_flit),
    .inj_ack_o(inj_ack), .out_flit_o(out_flit), .ej_flit_o(ej_flit)
  );

  function automatic logic [FW-1:0] mk(logic v, logic g, int dx, int dy, int pk, int sq);
    return {v, g, X_W'(dx), Y_W'(dy), PKT_W'(pk), SEQ_W'(sq)};
  endfunction

  localparam logic [FW-1:0] NL = '0;

  // {exp_ack, exp_ej, inj, w, s, e, n}; N-bound (3,1) E-bound (5,3) S-bound (3,6) W-bound (0,5) local (3,3)
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b0, 1'b0, NL, NL, NL, NL, mk(1,0,5,3,1,0)},
    {1'b0, 1'b0, NL, mk(1,0,6,0,2,0), mk(1,0,5,3,3,0), mk(1,0,7,7,4,0), mk(1,0,4,1,5,0)},
    {1'b0, 1'b0, NL, mk(1,0,0,5,6,0), mk(1,1,1,3,7,2), mk(1,0,2,2,8,0), mk(1,0,0,0,9,0)},
    {1'b0, 1'b0, NL, mk(1,1,5,3,10,0), mk(1,0,6,6,11,0), mk(1,0,7,3,12,0), mk(1,1,5,3,10,1)},
    {1'b1, 1'b1, mk(1,0,3,6,13,0), mk(1,0,3,3,14,0), NL, mk(1,0,3,3,15,0), NL},
    {1'b1, 1'b1, mk(1,0,3,1,16,0), mk(1,0,5,3,17,0), mk(1,1,3,3,18,1), mk(1,0,6,3,19,0), mk(1,0,3,3,20,0)},
    {1'b0, 1'b0, mk(1,0,3,6,21,0), mk(1,0,3,1,22,0), mk(1,0,0,5,23,0), mk(1,0,3,6,24,0), mk(1,0,5,3,25,0)},
    {1'b1, 1'b1, mk(1,1,0,0,26,0), mk(1,0,3,3,27,0), mk(1,0,3,0,28,0), mk(1,0,4,4,29,0), mk(1,0,2,6,30,0)},
    {1'b1, 1'b0, mk(1,0,3,6,31,0), NL, NL, NL, NL},
    {1'b0, 1'b1, NL, mk(1,1,3,3,32,1), NL, mk(1,1,3,3,32,2), mk(1,0,3,1,33,0)},
    {1'b0, 1'b0, NL, NL, mk(1,1,3,0,34,3), NL, NL},
    {1'b1, 1'b0, mk(1,0,1,3,35,0), NL, mk(1,0,3,7,36,0), NL, mk(1,0,3,5,37,0)}
  };

  function automatic int xy_port(logic [FW-1:0] f);
    int dx, dy;
    dx = int'(f[FW-3 -: X_W]);
    dy = int'(f[FW-3-X_W -: Y_W]);
    if (dx > MY_X) return 1;
    if (dx < MY_X) return 3;
    if (dy > MY_Y) return 2;
    if (dy < MY_Y) return 0;
    return 4;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic outputs_idle(string req);
    bit idle;
    idle = !ej_flit[FW-1] && !inj_ack;
    for (int p = 0; p < 4; p++) if (out_flit[p][FW-1]) idle = 1'b0;
    check(idle, req, "outputs idle", {28'(0), out_flit[0][FW-1], out_flit[1][FW-1],
          out_flit[2][FW-1], inj_ack}, 0);
  endtask

  task automatic run_vec(int i);
    logic [VW-1:0]      v;
    logic [3:0][FW-1:0] vin;
    logic [FW-1:0]      vinj, ej_exp;
    logic [FW-1:0]      want [5];
    int                 n_want, sel, n_out, best, n_vis;
    bit                 used [4];
    bit                 found, exp_ack;
    v    = VECS[i];
    vin  = v[4*FW-1:0];
    vinj = v[5*FW-1 -: FW];
    @(negedge clk);
    in_flit  = vin;
    inj_flit = vinj;
    @(negedge clk);
    in_flit  = '0;
    inj_flit = '0;
    outputs_idle("R1");
    @(negedge clk);
    // R4 expected ejection
    sel = -1;
    for (int p = 0; p < 4; p++) begin
      if (vin[p][FW-1] && xy_port(vin[p]) == 4) begin
        if (sel < 0
            || (vin[p][FW-2] && !vin[sel][FW-2])
            || (vin[p][FW-2] && vin[sel][FW-2] && vin[p][SEQ_W-1:0] < vin[sel][SEQ_W-1:0]))
          sel = p;
      end
    end
    ej_exp = (sel >= 0) ? vin[sel] : NL;
    check(ej_flit[FW-1] == v[VW-2], "R4", $sformatf("vec %0d eject valid", i),
          int'(ej_flit[FW-1]), int'(v[VW-2]));
    check(ej_flit == ej_exp, "R4", $sformatf("vec %0d eject flit", i),
          int'(ej_flit), int'(ej_exp));
    // R5 acceptance
    n_want = 0;
    for (int p = 0; p < 4; p++) if (vin[p][FW-1] && p != sel) begin
      want[n_want] = vin[p];
      n_want++;
    end
    exp_ack = vinj[FW-1] && n_want < 4;
    check(inj_ack == exp_ack && exp_ack == v[VW-1], "R5", $sformatf("vec %0d inj ack", i),
          int'(inj_ack), int'(v[VW-1]));
    if (exp_ack) begin
      want[n_want] = vinj;
      n_want++;
    end
    // R6 conservation
    for (int p = 0; p < 4; p++) used[p] = 1'b0;
    n_out = 0;
    for (int p = 0; p < 4; p++) if (out_flit[p][FW-1]) n_out++;
    found = (n_out == n_want);
    for (int k = 0; k < n_want; k++) begin
      bit hit;
      hit = 1'b0;
      for (int p = 0; p < 4; p++)
        if (!hit && !used[p] && out_flit[p] == want[k]) begin
          used[p] = 1'b1;
          hit = 1'b1;
        end
      if (!hit) found = 1'b0;
    end
    check(found, "R6", $sformatf("vec %0d flit set, count", i), n_out, n_want);
    // R7 lowest-seq golden flit productive
    best = -1;
    for (int p = 0; p < 4; p++)
      if (out_flit[p][FW-1] && out_flit[p][FW-2])
        if (best < 0 || out_flit[p][SEQ_W-1:0] < out_flit[best][SEQ_W-1:0]) best = p;
    if (best >= 0 && xy_port(out_flit[best]) != 4)
      check(xy_port(out_flit[best]) == best, "R7", $sformatf("vec %0d golden port", i),
            best, xy_port(out_flit[best]));
    // R8 / R3 lone flit productive
    n_vis = 0;
    for (int p = 0; p < 4; p++) if (out_flit[p][FW-1]) begin
      n_vis++;
      best = p;
    end
    if (n_vis == 1 && xy_port(out_flit[best]) != 4)
      check(xy_port(out_flit[best]) == best, "R8 R3", $sformatf("vec %0d lone port", i),
            best, xy_port(out_flit[best]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    outputs_idle("R2");
    rst_ni = 1'b1;
    @(negedge clk);
    outputs_idle("R2");

    for (int i = 0; i < NV; i++) run_vec(i);

    // Golden tie on one link: seq 0 must take east, seq 1 is deflected
    @(negedge clk);
    in_flit  = {mk(1,1,6,2,40,1), NL, NL, mk(1,1,6,2,40,0)};
    @(negedge clk);
    in_flit  = '0;
    @(negedge clk);
    check(out_flit[1] == mk(1,1,6,2,40,0), "R7", "seq tie on east",
          int'(out_flit[1]), int'(mk(1,1,6,2,40,0)));

    // Reset mid-traffic clears every output
    @(negedge clk);
    in_flit  = {mk(1,0,0,5,41,0), mk(1,0,3,6,42,0), mk(1,0,5,3,43,0), mk(1,0,3,3,44,0)};
    inj_flit = mk(1,0,3,1,45,0);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    outputs_idle("R2");
    in_flit  = '0;
    inj_flit = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    outputs_idle("R2");
    finish_run();
  end
endmodule